// File: doc/BRIEF.md
# Thyristor Phase-Leg Commutation Sequencer

This block sequences one phase leg built from two valves of antiparallel thyristors, one valve on each transformer terminal. It tracks which of the four thyristors carries the output current and issues an individual gate enable for each. Because a thyristor cannot be turned off from its gate, every change of conducting device must be a natural commutation. The change is either a change of terminal, requested by the modulator, or a change of polarity on the same terminal, forced by a reversal of the output current.

The modulator marks each commutation cycle with a cycle strobe and each half fundamental period with a half-period strobe. It raises a one-cycle request when the leg should change terminal. The block also receives the sign of the output current, a flag that says the current is too close to zero to trust that sign, and one conduction feedback bit per thyristor. A change of state is accepted only after the feedback bit of the incoming thyristor goes high. After a thyristor stops conducting, it is kept ungated for a recovery window.

Top module: `thyr_leg_commutator`

## Requirements
- R1: After reset the leg state is 1P (code 00), only gate bit 0 is on, `commuting` is low and `fault` is low.
- R2: The state code has the terminal in bit 1 (0 = terminal 1) and the polarity in bit 0 (0 = P, 1 = N): 1P=00, 1N=01, 2P=10, 2N=11. Gate bit i drives the thyristor whose state code is i, and at most one gate bit is on at any time.
- R3: A request (`acc_req`) starts a change to the other terminal with the opposite polarity letter (1P↔2N with positive current, 1N↔2P with negative current). It does so only when the current sign (`cur_pos`) matches the side of the present state.
- R4: While a change is pending, `commuting` is high and only the incoming thyristor's gate may be on. The state updates on the clock edge that samples that thyristor's `cond_fb` bit high, and not before.
- R5: A thyristor that has just stopped conducting keeps its gate off for TQ_CYC clock cycles after the confirming edge, even when it is the target of a new change.
- R6: Only one request-driven change is accepted between two `cycle_strobe` pulses. Later requests in that cycle are ignored.
- R7: When the current sign disagrees with the side of the present state, the leg changes to the antiparallel thyristor on the same terminal (1P→1N, 2N→2P and the reverse) without any request.
- R8: A reversal that comes before any request-driven change in a cycle cancels request-driven changes until the next `cycle_strobe`.
- R9: A reversal that comes after a completed request-driven change in the same cycle is followed at once, on its confirming edge, by an automatic change to the other terminal on the new side (for example 2N→2P→1N).
- R10: At most one reversal starts per half fundamental period. `half_strobe` allows the next one, and that reversal starts on the edge after the strobe at the earliest.
- R11: While `cur_zero` is high, no reversal and no request-driven change starts.
- R12: If the incoming gate has been on for CONF_TIMEOUT cycles with no conduction feedback, `fault` rises. The fault stays set until reset, with every gate off and the state frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pos | input | 1 | Output current sign, 1 = positive |
| cur_zero | input | 1 | Current too small for its sign to be trusted |
| acc_req | input | 1 | One-cycle request for a terminal change |
| cycle_strobe | input | 1 | Start of a commutation cycle |
| half_strobe | input | 1 | Start of a half fundamental period |
| cond_fb | input | 4 | Conduction feedback per thyristor, indexed by state code |
| gate_en | output | 4 | Gate enable per thyristor, indexed by state code |
| leg_state | output | 2 | Conducting thyristor, state code |
| commuting | output | 1 | A change is pending confirmation |
| fault | output | 1 | Confirmation timeout, sticky |

## Verification
The embedded properties check the following on every cycle: at most one gate is on, the state holds while a change is unconfirmed, a released thyristor is ungated on the next cycle, a zero-current flag stops any change from starting, no second reversal starts inside a half period, and the fault is sticky with all gates dark. The scenarios cover what needs a sequence of stimuli. These are the exact length of the recovery window, dropping a request after an early reversal, the automatic second change after a late reversal, and the exact cycle on which the timeout fires.

// File: rtl/leg_pkg.sv
package leg_pkg;
    localparam int LEG_THY = 4;

    typedef logic [1:0] leg_code_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COMM  = 2'd1,
        PH_FAULT = 2'd2
    } leg_phase_e;

    typedef enum logic [1:0] {
        K_ACC = 2'd0,
        K_REV = 2'd1,
        K_RST = 2'd2
    } leg_kind_e;

    // positive-current side: terminal bit equals polarity bit (1P=00, 2N=11)
    function automatic logic side_is_pos(input leg_code_t c);
        return c[1] == c[0];
    endfunction

    function automatic logic [LEG_THY-1:0] code_onehot(input leg_code_t c);
        return LEG_THY'(1) << c;
    endfunction
endpackage

// File: rtl/leg_tq_guard.sv
module leg_tq_guard
    import leg_pkg::*;
#(
    parameter int TQ_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rel_vld,
    input  leg_code_t          rel_idx,
    output logic [LEG_THY-1:0] blocked
);
    localparam int TQW = $clog2(TQ_CYC + 1);

    for (genvar i = 0; i < LEG_THY; i++) begin : g_thy
        logic [TQW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (rel_vld && rel_idx == leg_code_t'(i)) begin
                cnt_d = TQW'(TQ_CYC);
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - TQW'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign blocked[i] = (cnt_q != '0);
    end
endmodule

// File: rtl/leg_comm_fsm.sv
module leg_comm_fsm
    import leg_pkg::*;
#(
    parameter int CONF_TIMEOUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cur_pos,
    input  logic               cur_zero,
    input  logic               acc_req,
    input  logic               cycle_strobe,
    input  logic               half_strobe,
    input  logic [LEG_THY-1:0] cond_fb,
    input  logic [LEG_THY-1:0] blocked,
    output logic [LEG_THY-1:0] gate_en,
    output leg_code_t          leg_state,
    output logic               commuting,
    output logic               fault,
    output logic               rel_vld,
    output leg_code_t          rel_idx
);
    localparam int WDW = (CONF_TIMEOUT > 1) ? $clog2(CONF_TIMEOUT) : 1;

    typedef struct packed {
        leg_phase_e     phase;
        leg_code_t      state;
        leg_code_t      tgt;
        leg_kind_e      kind;
        logic [WDW-1:0] wd;
        logic           acc_done;
        logic           acc_drop;
        logic           rev_used;
        logic           restore;
    } fsm_t;

    fsm_t r_d, r_q;
    logic sign_ok, sign_bad, gating;

    always_comb begin
        r_d      = r_q;
        rel_vld  = 1'b0;
        rel_idx  = r_q.state;
        sign_ok  = !cur_zero && (cur_pos == side_is_pos(r_q.state));
        sign_bad = !cur_zero && (cur_pos != side_is_pos(r_q.state));
        gating   = !blocked[r_q.tgt];

        if (cycle_strobe) begin
            r_d.acc_done = 1'b0;
            r_d.acc_drop = 1'b0;
        end
        if (half_strobe) begin
            r_d.rev_used = 1'b0;
        end

        case (r_q.phase)
            PH_IDLE: begin
                if (sign_bad && !r_q.rev_used) begin
                    r_d.phase    = PH_COMM;
                    r_d.tgt      = r_q.state ^ 2'b01;
                    r_d.kind     = K_REV;
                    r_d.wd       = '0;
                    r_d.rev_used = 1'b1;
                    if (r_q.acc_done) r_d.restore  = 1'b1;
                    else              r_d.acc_drop = 1'b1;
                end else if (acc_req && sign_ok && !r_q.acc_done && !r_q.acc_drop) begin
                    r_d.phase = PH_COMM;
                    r_d.tgt   = r_q.state ^ 2'b11;
                    r_d.kind  = K_ACC;
                    r_d.wd    = '0;
                end
            end
            PH_COMM: begin
                if (cond_fb[r_q.tgt]) begin
                    r_d.state = r_q.tgt;
                    rel_vld   = 1'b1;
                    if (r_q.kind == K_REV && r_q.restore) begin
                        r_d.tgt     = r_q.tgt ^ 2'b11;
                        r_d.kind    = K_RST;
                        r_d.wd      = '0;
                        r_d.restore = 1'b0;
                    end else begin
                        r_d.phase = PH_IDLE;
                        if (r_q.kind != K_REV) r_d.acc_done = 1'b1;
                    end
                end else if (gating) begin
                    if (r_q.wd == WDW'(CONF_TIMEOUT - 1)) r_d.phase = PH_FAULT;
                    else                                  r_d.wd    = r_q.wd + WDW'(1);
                end
            end
            default: r_d.phase = PH_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_IDLE, state: 2'b00, tgt: 2'b00, kind: K_ACC,
                     wd: '0, acc_done: 1'b0, acc_drop: 1'b0,
                     rev_used: 1'b0, restore: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.phase)
            PH_IDLE: gate_en = code_onehot(r_q.state) & ~blocked;
            PH_COMM: gate_en = code_onehot(r_q.tgt) & ~blocked;
            default: gate_en = '0;
        endcase
    end

    assign leg_state = r_q.state;
    assign commuting = (r_q.phase == PH_COMM);
    assign fault     = (r_q.phase == PH_FAULT);

    AST_HOLD_UNCONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_COMM && !cond_fb[r_q.tgt]) |=> (r_q.state == $past(r_q.state))); // R4
    AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_IDLE && cur_zero) |=> (r_q.phase == PH_IDLE)); // R11
    AST_ONE_REVERSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_IDLE && r_q.rev_used && !half_strobe)
        |=> !(r_q.phase == PH_COMM && r_q.kind == K_REV)); // R10
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.phase == PH_FAULT) |=> (r_q.phase == PH_FAULT && r_q.state == $past(r_q.state))); // R12
endmodule

// File: rtl/thyr_leg_commutator.sv
module thyr_leg_commutator
    import leg_pkg::*;
#(
    parameter int TQ_CYC       = 8,
    parameter int CONF_TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cur_pos,
    input  logic       cur_zero,
    input  logic       acc_req,
    input  logic       cycle_strobe,
    input  logic       half_strobe,
    input  logic [3:0] cond_fb,
    output logic [3:0] gate_en,
    output logic [1:0] leg_state,
    output logic       commuting,
    output logic       fault
);
    logic [LEG_THY-1:0] blocked;
    logic               rel_vld;
    leg_code_t          rel_idx;

    leg_tq_guard #(.TQ_CYC(TQ_CYC)) u_tq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rel_vld (rel_vld),
        .rel_idx (rel_idx),
        .blocked (blocked)
    );

    leg_comm_fsm #(.CONF_TIMEOUT(CONF_TIMEOUT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cur_pos      (cur_pos),
        .cur_zero     (cur_zero),
        .acc_req      (acc_req),
        .cycle_strobe (cycle_strobe),
        .half_strobe  (half_strobe),
        .cond_fb      (cond_fb),
        .blocked      (blocked),
        .gate_en      (gate_en),
        .leg_state    (leg_state),
        .commuting    (commuting),
        .fault        (fault),
        .rel_vld      (rel_vld),
        .rel_idx      (rel_idx)
    );

    AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_en)); // R2
    AST_TQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld |=> !gate_en[$past(rel_idx)]); // R5
    AST_FAULT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (gate_en == 4'b0000 && !commuting)); // R12
endmodule

// File: tb/thyr_leg_commutator_bench.sv
`timescale 1ns/100ps
module thyr_leg_commutator_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cur_pos, cur_zero, acc_req, cycle_strobe, half_strobe;
    logic [3:0] cond_fb;
    logic [3:0] gate_en;
    logic [1:0] leg_state;
    logic       commuting, fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic [1:0] st;
        logic [3:0] g;
        logic       c;
        logic       f;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    thyr_leg_commutator #(.TQ_CYC(8), .CONF_TIMEOUT(16)) u_thyr_leg_commutator (
        .clk(clk), .rst_n(rst_n), .cur_pos(cur_pos), .cur_zero(cur_zero),
        .acc_req(acc_req), .cycle_strobe(cycle_strobe), .half_strobe(half_strobe),
        .cond_fb(cond_fb), .gate_en(gate_en), .leg_state(leg_state),
        .commuting(commuting), .fault(fault)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [1:0] st,
                              input logic [3:0] g, input logic c, input logic f);
        exp_t e;
        e.tag = tag; e.st = st; e.g = g; e.c = c; e.f = f;
        sb_q.push_back(e);
    endtask

    // monitor: compares queued expectations in the quiet half of the cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (leg_state !== e.st || gate_en !== e.g ||
                    commuting !== e.c || fault !== e.f) begin
                    fails++;
                    $display("FAIL %s: got state=%b gate=%b comm=%b fault=%b, expected state=%b gate=%b comm=%b fault=%b",
                             e.tag, leg_state, gate_en, commuting, fault, e.st, e.g, e.c, e.f);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected run completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cur_pos = 1'b1; cur_zero = 1'b0; acc_req = 1'b0;
        cycle_strobe = 1'b0; half_strobe = 1'b0; cond_fb = 4'b0000;
        tick(3);
        rst_n = 1'b1;
        tick();
        expect_out("R1 reset state", 2'b00, 4'b0001, 1'b0, 1'b0);

        // R3: request with positive current, 1P -> 2N
        acc_req = 1'b1; tick(); acc_req = 1'b0;
        expect_out("R3 request starts 1P->2N", 2'b00, 4'b1000, 1'b1, 1'b0);
        tick(2);
        expect_out("R4 no feedback, state held", 2'b00, 4'b1000, 1'b1, 1'b0);
        cond_fb = 4'b1000; tick(); cond_fb = 4'b0000; cycle_strobe = 1'b1;
        expect_out("R4 confirmed into 2N", 2'b11, 4'b1000, 1'b0, 1'b0);
        tick(); cycle_strobe = 1'b0; acc_req = 1'b1;
        tick(); acc_req = 1'b0;
        expect_out("R5 target 1P still in recovery", 2'b11, 4'b0000, 1'b1, 1'b0);
        tick(5);
        expect_out("R5 recovery last blocked cycle", 2'b11, 4'b0000, 1'b1, 1'b0);
        tick();
        expect_out("R5 recovery over, 1P gated", 2'b11, 4'b0001, 1'b1, 1'b0);
        cond_fb = 4'b0001; tick(); cond_fb = 4'b0000;
        expect_out("R3 confirmed 2N->1P", 2'b00, 4'b0001, 1'b0, 1'b0);

        // R6: second request in same cycle ignored
        acc_req = 1'b1; tick(); acc_req = 1'b0; tick();
        expect_out("R6 second request ignored", 2'b00, 4'b0001, 1'b0, 1'b0);

        // R7/R8: reversal before request
        cycle_strobe = 1'b1; tick(); cycle_strobe = 1'b0; cur_pos = 1'b0;
        tick();
        expect_out("R7 reversal 1P->1N started", 2'b00, 4'b0010, 1'b1, 1'b0);
        cond_fb = 4'b0010; tick(); cond_fb = 4'b0000;
        expect_out("R7 reversal confirmed", 2'b01, 4'b0010, 1'b0, 1'b0);
        acc_req = 1'b1; tick(); acc_req = 1'b0; tick();
        expect_out("R8 request dropped after reversal", 2'b01, 4'b0010, 1'b0, 1'b0);
        cycle_strobe = 1'b1; tick(); cycle_strobe = 1'b0; acc_req = 1'b1;
        tick(); acc_req = 1'b0;
        expect_out("R8 request accepted next cycle 1N->2P", 2'b01, 4'b0100, 1'b1, 1'b0);
        cond_fb = 4'b0100; tick(); cond_fb = 4'b0000;
        expect_out("R3 confirmed into 2P", 2'b10, 4'b0100, 1'b0, 1'b0);

        // R10: second reversal in same half period refused
        cur_pos = 1'b1; tick(3);
        expect_out("R10 reversal refused in half period", 2'b10, 4'b0100, 1'b0, 1'b0);
        half_strobe = 1'b1; tick(); half_strobe = 1'b0;
        expect_out("R10 no start on strobe edge", 2'b10, 4'b0100, 1'b0, 1'b0);
        tick();
        expect_out("R10 reversal 2P->2N after strobe", 2'b10, 4'b1000, 1'b1, 1'b0);
        // R9: late reversal triggers automatic terminal change
        cond_fb = 4'b1000; tick(); cond_fb = 4'b0000;
        expect_out("R9 auto change 2N->1P pending", 2'b11, 4'b0001, 1'b1, 1'b0);
        cond_fb = 4'b0001; tick(); cond_fb = 4'b0000;
        expect_out("R9 auto change confirmed", 2'b00, 4'b0001, 1'b0, 1'b0);

        // R11: zero-current flag blocks starts
        cycle_strobe = 1'b1; half_strobe = 1'b1; tick();
        cycle_strobe = 1'b0; half_strobe = 1'b0;
        cur_zero = 1'b1; cur_pos = 1'b0; acc_req = 1'b1; tick(); acc_req = 1'b0;
        tick(2);
        expect_out("R11 nothing starts near zero", 2'b00, 4'b0001, 1'b0, 1'b0);
        cur_zero = 1'b0; cur_pos = 1'b1; tick(2);
        expect_out("R11 quiet after release", 2'b00, 4'b0001, 1'b0, 1'b0);

        // R12: confirmation timeout
        tick(10);
        acc_req = 1'b1; tick(); acc_req = 1'b0;
        expect_out("R12 change started", 2'b00, 4'b1000, 1'b1, 1'b0);
        tick(15);
        expect_out("R12 no fault before timeout", 2'b00, 4'b1000, 1'b1, 1'b0);
        tick();
        expect_out("R12 fault at timeout", 2'b00, 4'b0000, 1'b0, 1'b1);
        cycle_strobe = 1'b1; tick(); cycle_strobe = 1'b0; acc_req = 1'b1; cond_fb = 4'b1000;
        tick(); acc_req = 1'b0; cond_fb = 4'b0000; tick();
        expect_out("R12 fault sticky", 2'b00, 4'b0000, 1'b0, 1'b1);

        tick(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule